// File: doc/BRIEF.md
# H-Bridge PWM Steering Logic

This block sits between a motor controller and the two half-bridge gate drivers that form an H-bridge. It takes one PWM waveform, a direction bit, a two-bit mode select and turns them into an enable and an input command for each driver. Each driver reads its pair as follows. Enable low switches both of its devices off. Enable high with input high switches on the upper device. Enable high with input low switches on the lower device.

Four modes exist. In anti-phase drive, the PWM duty cycle alone sets speed and direction: 50% means standstill. In sign-magnitude drive, the direction bit picks a diagonal pair of devices and PWM chops only the lower device of that pair. Brake switches on both lower devices so the motor winding is shorted. Coast switches everything off. Mode and direction requests are taken over only at the start of a PWM period, which is a rising edge of the sampled PWM. A one-cycle all-off gap separates the old drive pattern from the new one.

Each leg also guards its bootstrap supply. An upper device is switched on only after the lower device of the same leg has been on for a minimum number of clock cycles since that leg was last driven high. A low pulse that is too short is stretched until this count is reached.

Top module: `hbridge_pwm_steer`

## Requirements
- R1: While `rst_n` is low, all four outputs are 0. The active mode is coast. Every leg's recharge count is zero.
- R2: `mode_i` (0 anti-phase, 1 sign-magnitude, 2 brake, 3 coast) and `dir_i` are registered every cycle. They become active only on a cycle where the registered PWM has just risen. If the request differs from the active setting, that cycle drives all four outputs to 0 and the new setting applies from the next cycle. Direction is part of the request only in sign-magnitude mode.
- R3: In anti-phase mode both enables are 1. Leg A asks for its upper device while PWM is 1. Leg B asks for its upper device while PWM is 0.
- R4: In sign-magnitude mode with direction 0, leg A asks for its upper device all the time. Leg B drives enable 1 / input 0 while PWM is 1, and enable 0 / input 1 while PWM is 0.
- R5: In sign-magnitude mode with direction 1, the roles of the legs are swapped: leg B is held high and leg A is chopped.
- R6: In sign-magnitude mode, a leg whose enable is 0 always has its input at 1, so the driver never sees a gated enable with a static low input.
- R7: In brake mode both legs drive enable 1 / input 0, whatever PWM and `dir_i` do.
- R8: In coast mode all four outputs are 0, whatever PWM and `dir_i` do.
- R9: A leg enters the upper state only after `MIN_LOW` cycles in the lower state since it last left the upper state. Cycles with its enable at 0 neither add to this count nor clear it. Until the count is reached, a request for the upper state is served as the lower state.
- R10: An output reacts to a PWM edge two clock edges after the edge is presented at `pwm_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM waveform, period starts on its rising edge |
| dir_i | input | 1 | Direction select for sign-magnitude mode |
| mode_i | input | 2 | Drive mode request: 0 anti-phase, 1 sign-magnitude, 2 brake, 3 coast |
| in_a_o | output | 1 | Input command to half-bridge driver A |
| en_a_o | output | 1 | Enable command to half-bridge driver A |
| in_b_o | output | 1 | Input command to half-bridge driver B |
| en_b_o | output | 1 | Enable command to half-bridge driver B |

## Verification
Assertions check the following on every cycle:
- the all-off gap whenever the active setting changes, and that such a change only follows a PWM rising edge;
- the enable pattern of steady anti-phase and brake operation;
- the rule that a gated-off leg in sign-magnitude mode holds its input high;
- the recharge count before every entry into the upper state, measured by a separate counter.

Only the bench scenarios can show the following:
- that a request made in the middle of a period waits for the next rising edge;
- the two-edge latency from `pwm_i` to the pins;
- that direction changes have no effect in brake and coast;
- the exact length of stretched low pulses under short low phases.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  localparam int NUM_LEGS = 2;

  typedef enum logic [1:0] {
    MODE_ANTI    = 2'd0,
    MODE_SIGNMAG = 2'd1,
    MODE_BRAKE   = 2'd2,
    MODE_COAST   = 2'd3
  } drive_mode_e;

  typedef struct packed {
    logic en;
    logic in;
  } leg_cmd_t;

  localparam leg_cmd_t LEG_OFF  = '{en: 1'b0, in: 1'b0};
  localparam leg_cmd_t LEG_PARK = '{en: 1'b0, in: 1'b1};
  localparam leg_cmd_t LEG_LOW  = '{en: 1'b1, in: 1'b0};
  localparam leg_cmd_t LEG_HIGH = '{en: 1'b1, in: 1'b1};

endpackage

// File: rtl/hbs_cfg_sync.sv
module hbs_cfg_sync
  import hbs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pwm_i,
  input  logic        dir_i,
  input  logic [1:0]  mode_i,
  output logic        pwm_o,
  output drive_mode_e act_mode_o,
  output logic        act_dir_o,
  output logic        blank_o
);

  logic        pwm_q, pwm_qq;
  drive_mode_e mode_q;
  logic        dir_q;
  drive_mode_e act_mode;
  logic        act_dir;
  logic        req_dir_eff;
  logic        period_start;

  // direction matters only for sign-magnitude requests
  assign req_dir_eff  = (mode_q == MODE_SIGNMAG) ? dir_q : 1'b0;
  assign period_start = pwm_q & ~pwm_qq;
  assign blank_o      = period_start &&
                        ((mode_q != act_mode) || (req_dir_eff != act_dir));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q    <= 1'b0;
      pwm_qq   <= 1'b0;
      mode_q   <= MODE_COAST;
      dir_q    <= 1'b0;
      act_mode <= MODE_COAST;
      act_dir  <= 1'b0;
    end else begin
      pwm_q  <= pwm_i;
      pwm_qq <= pwm_q;
      mode_q <= drive_mode_e'(mode_i);
      dir_q  <= dir_i;
      if (blank_o) begin
        act_mode <= mode_q;
        act_dir  <= req_dir_eff;
      end
    end
  end

  assign pwm_o      = pwm_q;
  assign act_mode_o = act_mode;
  assign act_dir_o  = act_dir;

  // R2: the active setting moves only right after a PWM period start
  assert_cfg_on_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mode) || !$stable(act_dir)) |-> $past(pwm_q && !pwm_qq));

  // R2: a change adopts exactly the registered request
  assert_cfg_adopts_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blank_o) |-> (act_mode == $past(mode_q)));

endmodule

// File: rtl/hbs_steer.sv
module hbs_steer
  import hbs_pkg::*;
(
  input  drive_mode_e                 mode_i,
  input  logic                        dir_i,
  input  logic                        pwm_i,
  input  logic                        blank_i,
  output leg_cmd_t [NUM_LEGS-1:0]     req_o
);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    localparam logic LEG_ID = (g != 0);
    leg_cmd_t req;

    always_comb begin
      req = LEG_OFF;
      if (!blank_i) begin
        unique case (mode_i)
          MODE_ANTI:    req = (pwm_i ^ LEG_ID) ? LEG_HIGH : LEG_LOW;
          MODE_SIGNMAG: begin
            if (dir_i == LEG_ID) req = LEG_HIGH;
            else                 req = pwm_i ? LEG_LOW : LEG_PARK;
          end
          MODE_BRAKE:   req = LEG_LOW;
          default:      req = LEG_OFF;
        endcase
      end
    end

    assign req_o[g] = req;
  end

endmodule

// File: rtl/hbs_leg_guard.sv
module hbs_leg_guard
  import hbs_pkg::*;
#(
  parameter int MIN_LOW = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  leg_cmd_t req_i,
  output leg_cmd_t cmd_o
);

  localparam int             CNT_W   = $clog2(MIN_LOW + 1);
  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_LOW);

  leg_cmd_t         cmd_q;
  leg_cmd_t         grant;
  logic [CNT_W-1:0] low_cnt;
  logic             charged;

  assign charged = (low_cnt == MIN_CNT);

  always_comb begin
    grant = req_i;
    if (req_i == LEG_HIGH && cmd_q != LEG_HIGH && !charged)
      grant = LEG_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= LEG_OFF;
      low_cnt <= '0;
    end else begin
      cmd_q <= grant;
      if (grant == LEG_HIGH)
        low_cnt <= '0;
      else if (grant == LEG_LOW && !charged)
        low_cnt <= low_cnt + 1'b1;
    end
  end

  assign cmd_o = cmd_q;

  // independent tally of low-side cycles seen at the output
  logic [CNT_W-1:0] seen_low;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 seen_low <= '0;
    else if (cmd_q == LEG_HIGH) seen_low <= '0;
    else if (cmd_q == LEG_LOW && seen_low != MIN_CNT)
      seen_low <= seen_low + 1'b1;
  end

  // R9: every entry into the upper state follows a full recharge
  assert_recharge_before_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == LEG_HIGH && $past(cmd_q) != LEG_HIGH) |-> (seen_low == MIN_CNT));

endmodule

// File: rtl/hbridge_pwm_steer.sv
module hbridge_pwm_steer
  import hbs_pkg::*;
#(
  parameter int MIN_LOW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_i,
  input  logic       dir_i,
  input  logic [1:0] mode_i,
  output logic       in_a_o,
  output logic       en_a_o,
  output logic       in_b_o,
  output logic       en_b_o
);

  logic                    pwm_s;
  drive_mode_e             act_mode;
  logic                    act_dir;
  logic                    blank;
  leg_cmd_t [NUM_LEGS-1:0] req;
  leg_cmd_t [NUM_LEGS-1:0] cmd;

  hbs_cfg_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_i      (pwm_i),
    .dir_i      (dir_i),
    .mode_i     (mode_i),
    .pwm_o      (pwm_s),
    .act_mode_o (act_mode),
    .act_dir_o  (act_dir),
    .blank_o    (blank)
  );

  hbs_steer u_steer (
    .mode_i  (act_mode),
    .dir_i   (act_dir),
    .pwm_i   (pwm_s),
    .blank_i (blank),
    .req_o   (req)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_guard
    hbs_leg_guard #(.MIN_LOW(MIN_LOW)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (req[g]),
      .cmd_o (cmd[g])
    );
  end

  assign en_a_o = cmd[0].en;
  assign in_a_o = cmd[0].in;
  assign en_b_o = cmd[1].en;
  assign in_b_o = cmd[1].in;

  // R1: reset holds both drivers disabled
  assert_reset_disabled_R1: assert property (@(posedge clk)
    !rst_n |-> (!en_a_o && !en_b_o));

  // R2: a setting change produces one all-off cycle
  assert_change_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_mode) || !$stable(act_dir)) |->
      (!en_a_o && !in_a_o && !en_b_o && !in_b_o));

  // R3: steady anti-phase keeps both drivers enabled
  assert_anti_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_ANTI && $stable(act_mode)) |-> (en_a_o && en_b_o));

  // R6: a gated-off leg in sign-magnitude mode parks its input high
  assert_park_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_SIGNMAG && $stable(act_mode) && $stable(act_dir)) |->
      ((en_a_o || in_a_o) && (en_b_o || in_b_o)));

  // R7: steady brake shorts the winding through both lower devices
  assert_brake_lows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == MODE_BRAKE && $stable(act_mode)) |->
      (en_a_o && !in_a_o && en_b_o && !in_b_o));

endmodule

// File: tb/hbridge_pwm_steer_tb.sv
`timescale 1ns/1ps
module hbridge_pwm_steer_tb;

  localparam int MIN_LOW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm = 1'b0;
  logic       dir = 1'b0;
  logic [1:0] mode = 2'd3;
  logic       in_a, en_a, in_b, en_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  hbridge_pwm_steer #(.MIN_LOW(MIN_LOW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .dir_i(dir), .mode_i(mode),
    .in_a_o(in_a), .en_a_o(en_a), .in_b_o(in_b), .en_b_o(en_b)
  );

  always #4 clk = ~clk;

  // reference state: {en,in} per leg, index 0 = A
  logic       m_pq, m_pqq, m_dq, m_adir;
  logic [1:0] m_mq, m_amode, m_used_mode;
  logic [1:0] m_leg [2];
  int         m_cnt [2];
  logic       m_blank;
  string      m_tag;

  task automatic check(input bit ok, input string tag,
                       input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [1:0] want_leg(input int leg, input logic [1:0] md,
                                          input logic dr, input logic p);
    logic id;
    id = (leg != 0);
    case (md)
      2'd0: return {1'b1, p ^ id};
      2'd1: return (dr == id) ? 2'b11 : (p ? 2'b10 : 2'b01);
      2'd2: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  task automatic model_reset();
    m_pq = 0; m_pqq = 0; m_dq = 0; m_adir = 0;
    m_mq = 2'd3; m_amode = 2'd3; m_used_mode = 2'd3; m_blank = 0;
    for (int l = 0; l < 2; l++) begin m_leg[l] = 2'b00; m_cnt[l] = 0; end
    m_tag = "R1";
  endtask

  task automatic model_step();
    logic rise, chg, edir, stretched;
    logic [1:0] r, nleg [2];
    int ncnt [2];
    rise = m_pq & ~m_pqq;
    edir = (m_mq == 2'd1) ? m_dq : 1'b0;
    chg  = rise && ((m_mq != m_amode) || (edir != m_adir));
    stretched = 0;
    for (int l = 0; l < 2; l++) begin
      r = chg ? 2'b00 : want_leg(l, m_amode, m_adir, m_pq);
      if (r == 2'b11 && m_leg[l] != 2'b11 && m_cnt[l] != MIN_LOW) begin
        r = 2'b10; stretched = 1;
      end
      nleg[l] = r;
      ncnt[l] = m_cnt[l];
      if (r == 2'b11) ncnt[l] = 0;
      else if (r == 2'b10 && m_cnt[l] != MIN_LOW) ncnt[l] = m_cnt[l] + 1;
    end
    if (chg) m_tag = "R2";
    else if (stretched) m_tag = "R9";
    else case (m_amode)
      2'd0: m_tag = "R3";
      2'd1: m_tag = m_adir ? "R5" : "R4";
      2'd2: m_tag = "R7";
      default: m_tag = "R8";
    endcase
    m_used_mode = m_amode;
    m_blank = chg;
    if (chg) begin m_amode = m_mq; m_adir = edir; end
    for (int l = 0; l < 2; l++) begin m_leg[l] = nleg[l]; m_cnt[l] = ncnt[l]; end
    m_pqq = m_pq; m_pq = pwm; m_mq = mode; m_dq = dir;
  endtask

  task automatic tick();
    logic [3:0] got, exp;
    @(posedge clk);
    @(negedge clk);
    model_step();
    got = {en_a, in_a, en_b, in_b};
    exp = {m_leg[0], m_leg[1]};
    check(got == exp, m_tag, got, exp);
    if (m_used_mode == 2'd1 && !m_blank) begin
      if (!m_leg[0][1]) check(in_a == 1'b1, "R6", got, exp);
      if (!m_leg[1][1]) check(in_b == 1'b1, "R6", got, exp);
    end
  endtask

  task automatic pwm_run(input logic [1:0] md, input logic dr, input int period,
                         input int high, input int nper);
    mode = md; dir = dr;
    for (int p = 0; p < nper; p++)
      for (int c = 0; c < period; c++) begin
        pwm = (c < high);
        tick();
      end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1F2E3D4C));
    model_reset();
    repeat (3) @(negedge clk);
    check({en_a, in_a, en_b, in_b} == 4'b0000, "R1",
          {en_a, in_a, en_b, in_b}, 4'b0000);
    rst_n = 1'b1;

    // R3: anti-phase at 50%, 25%, 75% duty
    pwm_run(2'd0, 1'b0, 32, 16, 4);
    pwm_run(2'd0, 1'b0, 32, 8, 3);
    pwm_run(2'd0, 1'b1, 32, 24, 3);
    // R9: low phase shorter than the recharge count gets stretched
    pwm_run(2'd0, 1'b0, 16, 14, 4);

    // R10: two-edge latency from pwm_i to the pins
    mode = 2'd0; pwm = 1'b0;
    repeat (20) tick();
    pwm = 1'b1;
    tick();
    check(in_a == 1'b0, "R10", {3'b0, in_a}, 4'b0000);
    tick();
    check(in_a == 1'b1, "R10", {3'b0, in_a}, 4'b0001);

    // R2: a request made mid-period waits for the next rising edge
    mode = 2'd2;
    repeat (3) begin
      tick();
      check(in_a == 1'b1 && en_a, "R2", {en_a, in_a, en_b, in_b}, 4'b1110);
    end
    pwm = 1'b0;
    repeat (4) tick();
    pwm = 1'b1;
    tick();
    tick();
    check({en_a, in_a, en_b, in_b} == 4'b0000, "R2",
          {en_a, in_a, en_b, in_b}, 4'b0000);
    tick();
    check({en_a, in_a, en_b, in_b} == 4'b1010, "R7",
          {en_a, in_a, en_b, in_b}, 4'b1010);

    // R4, R5, R6: sign-magnitude both directions
    pwm_run(2'd1, 1'b0, 32, 12, 4);
    pwm_run(2'd1, 1'b1, 32, 20, 4);
    pwm_run(2'd1, 1'b0, 24, 3, 3);
    // R7, R8: direction toggling has no effect
    for (int k = 0; k < 6; k++) pwm_run(2'd2, k[0], 10, 5, 1);
    for (int k = 0; k < 6; k++) pwm_run(2'd3, k[0], 10, 5, 1);

    // random segments
    for (int s = 0; s < 80; s++) begin
      int per, hi;
      per = 8 + int'($urandom % 40);
      hi  = int'($urandom % (per + 1));
      pwm_run(2'($urandom % 4), 1'($urandom % 2), per, hi, 1 + int'($urandom % 4));
    end

    // R1: asynchronous reset in the middle of operation
    pwm_run(2'd0, 1'b0, 20, 10, 2);
    rst_n = 1'b0;
    #1;
    check(!en_a && !en_b, "R1", {en_a, in_a, en_b, in_b}, 4'b0000);
    model_reset();
    repeat (2) @(negedge clk);
    check({en_a, in_a, en_b, in_b} == 4'b0000, "R1",
          {en_a, in_a, en_b, in_b}, 4'b0000);
    rst_n = 1'b1;
    pwm_run(2'd0, 1'b0, 20, 10, 3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule